// File: doc/BRIEF.md
# Hash Engine Block Input Controller

This block sits in front of a hash core and manages how message data reaches it. Software or a DMA engine writes one 64-byte block as sixteen 32-bit words through a simple register port. The controller tracks which words have arrived. When the block is complete, or when software marks a short final block with the close flag, it copies the block into a working buffer, starts the core and reports that the input side is free again. In DMA mode it also raises a request for the next block.

The core reports through two pulses. Block-done frees the working buffer. Hash-done loads the digest words and sets the output-ready flag, which can also pull an active-low interrupt line. Software reads back the digest words, and the number of valid words follows the selected algorithm. Software can also read and restore a running byte count, so that a long hash can be suspended and resumed later.

Register map, by word address: 0x00–0x0F input words, 0x10–0x1F digest words, 0x20 config, 0x21 status, 0x22 mask, 0x23 byte count.

Top module: `hash_input_ctrl`

## Requirements
- R1: After reset, status reads 0x1 (input-ready set, output-ready clear), irqN is 1, dmaReq and coreStart are 0, and the byte count reads 0.
- R2: One cycle after the sixteenth distinct input word is written, coreStart pulses for one cycle. coreBlock carries word i in bits [32i+31:32i], coreWordMask is 0xFFFF and coreLast is 0.
- R3: Input-ready (status bit 0) clears on the first input-word write of a new block and sets again when the block is handed to the working buffer.
- R4: A partly filled block is not handed off while config bit 2 (close) is 0. Once close is set, the block is handed off in the next cycle with coreWordMask equal to the written words and coreLast at 1, and the close bit reads back as 0 afterwards.
- R5: Writing an input word again before handoff overwrites it, and the last value written is the one delivered to the core.
- R6: While the working buffer is busy (from a handoff until coreBlockDone), a completed block is held. Its coreStart follows one cycle after coreBlockDone.
- R7: With config bit 0 (DMA enable) set, dmaReq pulses for one cycle at each handoff, and also when the enable goes from 0 to 1 while input-ready is set. With it clear, dmaReq stays 0.
- R8: coreHashDone sets output-ready (status bit 1) whatever mask bit 1 (register 0x22) holds. Writing 1 to status bit 1 clears it.
- R9: irqN is 0 exactly when output-ready, config bit 1 (interrupt enable) and mask bit 1 are all set, and it returns to 1 when any of them clears.
- R10: coreHashDone loads the digest words. Reading 0x10+i returns word i when i is below the word count of the algorithm in config bits 6:4, and 0 otherwise. The counts are: 0 = 4 words, 1 = 5, 2 = 7, 3 = 8, 4 = 12, 5 = 16, and 6 or 7 = none.
- R11: The byte count (0x23) can be written. Each handoff adds four times the number of words in the handed-off block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 6 | Register word address |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr (combinational) |
| coreBlockDone | input | 1 | Core finished with the working buffer |
| coreHashDone | input | 1 | Core finished the whole hash, digest valid |
| coreDigest | input | 512 | Digest words from the core, word i at [32i+31:32i] |
| coreStart | output | 1 | One-cycle start pulse for a new working block |
| coreBlock | output | 512 | Working buffer contents |
| coreWordMask | output | 16 | Words valid in the working buffer |
| coreLast | output | 1 | Working block is the final, closed block |
| dmaReq | output | 1 | One-cycle request for the next block |
| irqN | output | 1 | Active-low completion interrupt |

## Verification
A fill mask that is wrong shows up at the ports in the cycle after the sixteenth write: coreStart stays silent, or it fires early with a short coreWordMask. A stale busy flag shows up as a coreStart that either never follows coreBlockDone or comes while the core is still working. Status flags that drift are visible on the next read of status or the next level of irqN. A bad working-buffer copy appears on coreBlock in the same cycle as the start pulse. A bad algorithm decode shows only on digest reads at the edge of each word count, so the bench probes the last valid word and the first invalid one for every algorithm code.

// File: rtl/hic_pkg.sv
package hic_pkg;

  localparam int WORDS = 16;
  localparam int DW = 32;
  localparam int AW = 6;

  // register word addresses in the control page
  localparam logic [1:0] CTRL_CFG = 2'd0;
  localparam logic [1:0] CTRL_STAT = 2'd1;
  localparam logic [1:0] CTRL_MASK = 2'd2;
  localparam logic [1:0] CTRL_CNT = 2'd3;

  typedef struct packed {
    logic [WORDS-1:0] wordWe;
    logic handoff;
    logic capDigest;
  } hic_strobe_t;

  // valid digest words for each algorithm code
  function automatic int digestWords(logic [2:0] algo);
    case (algo)
      3'd0: return 4;
      3'd1: return 5;
      3'd2: return 7;
      3'd3: return 8;
      3'd4: return 12;
      3'd5: return 16;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/hic_datapath.sv
module hic_datapath
  import hic_pkg::*;
#(
  parameter int NUM_WORDS = WORDS,
  parameter int WORD_W = DW,
  localparam int IDX_W = $clog2(NUM_WORDS)
) (
  input  logic clk,
  input  logic rstN,
  input  hic_strobe_t strobe,
  input  logic [WORD_W-1:0] regWdata,
  input  logic [AW-1:0] regAddr,
  input  logic [NUM_WORDS-1:0] fillMask,
  input  logic closeFlag,
  input  logic [2:0] algoSel,
  input  logic [NUM_WORDS*WORD_W-1:0] coreDigest,
  output logic [NUM_WORDS*WORD_W-1:0] coreBlock,
  output logic [NUM_WORDS-1:0] coreWordMask,
  output logic coreLast,
  output logic [WORD_W-1:0] dataRdata
);

  logic [WORD_W-1:0] inBuf [NUM_WORDS];
  logic [WORD_W-1:0] workBuf [NUM_WORDS];
  logic [WORD_W-1:0] digestQ [NUM_WORDS];
  logic [NUM_WORDS-1:0] workMaskQ;
  logic workLastQ;

  logic [IDX_W-1:0] rdIdx;
  assign rdIdx = regAddr[IDX_W-1:0];

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rstN) begin
        inBuf[i] <= '0;
        workBuf[i] <= '0;
        digestQ[i] <= '0;
      end else begin
        if (strobe.wordWe[i]) inBuf[i] <= regWdata;
        if (strobe.handoff) workBuf[i] <= inBuf[i];
        if (strobe.capDigest) digestQ[i] <= coreDigest[i*WORD_W +: WORD_W];
      end
    end
    assign coreBlock[i*WORD_W +: WORD_W] = workBuf[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      workMaskQ <= '0;
      workLastQ <= 1'b0;
    end else if (strobe.handoff) begin
      workMaskQ <= fillMask;
      workLastQ <= closeFlag;
    end
  end

  assign coreWordMask = workMaskQ;
  assign coreLast = workLastQ;

  // page 0: input words, page 1: digest words limited by algorithm
  always_comb begin
    dataRdata = '0;
    if (!regAddr[IDX_W]) begin
      dataRdata = inBuf[rdIdx];
    end else if (int'(rdIdx) < digestWords(algoSel)) begin
      dataRdata = digestQ[rdIdx];
    end
  end

  p_work_mask_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.handoff |=> coreWordMask == $past(fillMask));

  p_work_last_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.handoff |=> coreLast == $past(closeFlag));

endmodule

// File: rtl/hic_control.sv
module hic_control
  import hic_pkg::*;
#(
  parameter int NUM_WORDS = WORDS,
  parameter int WORD_W = DW,
  parameter int CNT_W = 32,
  localparam int IDX_W = $clog2(NUM_WORDS),
  localparam int BYTES_PER_WORD = WORD_W / 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic regWe,
  input  logic [AW-1:0] regAddr,
  input  logic [WORD_W-1:0] regWdata,
  input  logic coreBlockDone,
  input  logic coreHashDone,
  output hic_strobe_t strobe,
  output logic [NUM_WORDS-1:0] fillMask,
  output logic closeFlag,
  output logic [2:0] algoSel,
  output logic coreStart,
  output logic dmaReq,
  output logic irqN,
  output logic [WORD_W-1:0] ctrlRdata
);

  logic [NUM_WORDS-1:0] fillQ;
  logic workBusyQ;
  logic inReadyQ;
  logic outReadyQ;
  logic dmaEnQ;
  logic irqEnQ;
  logic closeQ;
  logic [2:0] algoQ;
  logic maskInQ;
  logic maskOutQ;
  logic [CNT_W-1:0] countQ;
  logic coreStartQ;
  logic dmaReqQ;

  logic dataWr;
  logic ctrlWr;
  logic cfgWr;
  logic statWr;
  logic maskWr;
  logic cntWr;
  logic [NUM_WORDS-1:0] wordWe;
  logic blockFull;
  logic handoff;
  logic [CNT_W-1:0] addBytes;

  assign dataWr = regWe && (regAddr[AW-1:IDX_W] == '0);
  assign ctrlWr = regWe && regAddr[AW-1];
  assign cfgWr = ctrlWr && (regAddr[1:0] == CTRL_CFG);
  assign statWr = ctrlWr && (regAddr[1:0] == CTRL_STAT);
  assign maskWr = ctrlWr && (regAddr[1:0] == CTRL_MASK);
  assign cntWr = ctrlWr && (regAddr[1:0] == CTRL_CNT);

  always_comb begin
    wordWe = '0;
    if (dataWr) wordWe[regAddr[IDX_W-1:0]] = 1'b1;
  end

  assign blockFull = &fillQ;
  assign handoff = !workBusyQ && (blockFull || (closeQ && (|fillQ)));
  assign addBytes = CNT_W'(BYTES_PER_WORD * $countones(fillQ));

  assign strobe.wordWe = wordWe;
  assign strobe.handoff = handoff;
  assign strobe.capDigest = coreHashDone;

  // fill tracking, buffer ownership and input-ready
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillQ <= '0;
      workBusyQ <= 1'b0;
      inReadyQ <= 1'b1;
    end else begin
      fillQ <= (handoff ? '0 : fillQ) | wordWe;
      if (handoff) workBusyQ <= 1'b1;
      else if (coreBlockDone) workBusyQ <= 1'b0;
      if (dataWr && (handoff || fillQ == '0)) inReadyQ <= 1'b0;
      else if (handoff) inReadyQ <= 1'b1;
    end
  end

  // configuration, mask and byte count
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dmaEnQ <= 1'b0;
      irqEnQ <= 1'b0;
      closeQ <= 1'b0;
      algoQ <= '0;
      maskInQ <= 1'b0;
      maskOutQ <= 1'b0;
      countQ <= '0;
    end else begin
      if (cfgWr) begin
        dmaEnQ <= regWdata[0];
        irqEnQ <= regWdata[1];
        closeQ <= regWdata[2];
        algoQ <= regWdata[6:4];
      end else if (handoff) begin
        closeQ <= 1'b0;
      end
      if (maskWr) begin
        maskInQ <= regWdata[0];
        maskOutQ <= regWdata[1];
      end
      if (cntWr) countQ <= regWdata[CNT_W-1:0];
      else if (handoff) countQ <= countQ + addBytes;
    end
  end

  // completion flag, start and request pulses
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outReadyQ <= 1'b0;
      coreStartQ <= 1'b0;
      dmaReqQ <= 1'b0;
    end else begin
      if (coreHashDone) outReadyQ <= 1'b1;
      else if (statWr && regWdata[1]) outReadyQ <= 1'b0;
      coreStartQ <= handoff;
      dmaReqQ <= (handoff && dmaEnQ && !(cfgWr && !regWdata[0]))
              || (cfgWr && regWdata[0] && !dmaEnQ && inReadyQ);
    end
  end

  assign fillMask = fillQ;
  assign closeFlag = closeQ;
  assign algoSel = algoQ;
  assign coreStart = coreStartQ;
  assign dmaReq = dmaReqQ;
  assign irqN = !(outReadyQ && irqEnQ && maskOutQ);

  always_comb begin
    ctrlRdata = '0;
    case (regAddr[1:0])
      CTRL_CFG: ctrlRdata = WORD_W'({algoQ, 1'b0, closeQ, irqEnQ, dmaEnQ});
      CTRL_STAT: ctrlRdata = WORD_W'({outReadyQ, inReadyQ});
      CTRL_MASK: ctrlRdata = WORD_W'({maskOutQ, maskInQ});
      default: ctrlRdata = WORD_W'(countQ);
    endcase
  end

  p_start_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    coreStartQ |=> !coreStartQ);

  p_start_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    coreStartQ |-> workBusyQ);

  p_ready_handoff_r3: assert property (@(posedge clk) disable iff (!rstN)
    (handoff && !dataWr) |=> inReadyQ && fillQ == '0);

  p_out_from_core_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outReadyQ) |-> $past(coreHashDone));

  p_dma_enabled_r7: assert property (@(posedge clk) disable iff (!rstN)
    dmaReqQ |-> dmaEnQ);

endmodule

// File: rtl/hash_input_ctrl.sv
module hash_input_ctrl
  import hic_pkg::*;
#(
  parameter int NUM_WORDS = WORDS,
  parameter int WORD_W = DW,
  parameter int CNT_W = 32
) (
  input  logic clk,
  input  logic rstN,
  input  logic regWe,
  input  logic [AW-1:0] regAddr,
  input  logic [WORD_W-1:0] regWdata,
  output logic [WORD_W-1:0] regRdata,
  input  logic coreBlockDone,
  input  logic coreHashDone,
  input  logic [NUM_WORDS*WORD_W-1:0] coreDigest,
  output logic coreStart,
  output logic [NUM_WORDS*WORD_W-1:0] coreBlock,
  output logic [NUM_WORDS-1:0] coreWordMask,
  output logic coreLast,
  output logic dmaReq,
  output logic irqN
);

  hic_strobe_t strobe;
  logic [NUM_WORDS-1:0] fillMask;
  logic closeFlag;
  logic [2:0] algoSel;
  logic [WORD_W-1:0] ctrlRdata;
  logic [WORD_W-1:0] dataRdata;

  hic_control #(
    .NUM_WORDS(NUM_WORDS),
    .WORD_W(WORD_W),
    .CNT_W(CNT_W)
  ) ctrl_i (
    .clk(clk),
    .rstN(rstN),
    .regWe(regWe),
    .regAddr(regAddr),
    .regWdata(regWdata),
    .coreBlockDone(coreBlockDone),
    .coreHashDone(coreHashDone),
    .strobe(strobe),
    .fillMask(fillMask),
    .closeFlag(closeFlag),
    .algoSel(algoSel),
    .coreStart(coreStart),
    .dmaReq(dmaReq),
    .irqN(irqN),
    .ctrlRdata(ctrlRdata)
  );

  hic_datapath #(
    .NUM_WORDS(NUM_WORDS),
    .WORD_W(WORD_W)
  ) dp_i (
    .clk(clk),
    .rstN(rstN),
    .strobe(strobe),
    .regWdata(regWdata),
    .regAddr(regAddr),
    .fillMask(fillMask),
    .closeFlag(closeFlag),
    .algoSel(algoSel),
    .coreDigest(coreDigest),
    .coreBlock(coreBlock),
    .coreWordMask(coreWordMask),
    .coreLast(coreLast),
    .dataRdata(dataRdata)
  );

  assign regRdata = regAddr[AW-1] ? ctrlRdata : dataRdata;

endmodule

// File: tb/hash_input_ctrl_tb.sv
module hash_input_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NW = 16;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [5:0] regAddr = '0;
  logic [W-1:0] regWdata = '0;
  logic [W-1:0] regRdata;
  logic coreBlockDone = 1'b0;
  logic coreHashDone = 1'b0;
  logic [NW*W-1:0] coreDigest = '0;
  logic coreStart;
  logic [NW*W-1:0] coreBlock;
  logic [NW-1:0] coreWordMask;
  logic coreLast;
  logic dmaReq;
  logic irqN;

  int checks = 0;
  int errors = 0;

  hash_input_ctrl dut_i (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata),
    .coreBlockDone(coreBlockDone), .coreHashDone(coreHashDone),
    .coreDigest(coreDigest), .coreStart(coreStart), .coreBlock(coreBlock),
    .coreWordMask(coreWordMask), .coreLast(coreLast), .dmaReq(dmaReq),
    .irqN(irqN)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // R10 table: {algo, word index, word expected valid}
  localparam int NVEC = 12;
  localparam logic [8:0] DIG_VEC [NVEC] = '{
    {3'd0, 4'd3, 1'b1, 1'b0}, {3'd0, 4'd4, 1'b0, 1'b0},
    {3'd1, 4'd4, 1'b1, 1'b0}, {3'd1, 4'd5, 1'b0, 1'b0},
    {3'd2, 4'd6, 1'b1, 1'b0}, {3'd2, 4'd7, 1'b0, 1'b0},
    {3'd3, 4'd7, 1'b1, 1'b0}, {3'd3, 4'd8, 1'b0, 1'b0},
    {3'd4, 4'd11, 1'b1, 1'b0}, {3'd4, 4'd12, 1'b0, 1'b0},
    {3'd5, 4'd15, 1'b1, 1'b0}, {3'd6, 4'd0, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [W-1:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [W-1:0] d);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic pulseDone(input bit hashDone);
    @(negedge clk);
    if (hashDone) coreHashDone = 1'b1; else coreBlockDone = 1'b1;
    @(negedge clk);
    coreHashDone = 1'b0; coreBlockDone = 1'b0;
  endtask

  task automatic fillBlock(input logic [W-1:0] base);
    for (int i = 0; i < NW; i++) wr(6'(i), base + W'(i));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] r;
    for (int i = 0; i < NW; i++) coreDigest[i*W +: W] = 32'hD000_0000 + W'(i);
    repeat (3) tick();
    rstN = 1'b1;
    tick();

    // R1 reset state
    rd(6'h21, r); check("R1 status", r, 32'h1);
    rd(6'h23, r); check("R1 count", r, 32'h0);
    check("R1 irqN", W'(irqN), 32'h1);
    check("R1 dmaReq", W'(dmaReq), 32'h0);
    check("R1 coreStart", W'(coreStart), 32'h0);

    // R3 first write clears input-ready; R5 overwrite
    for (int i = 0; i < NW - 1; i++) wr(6'(i), 32'hA000_0000 + W'(i));
    rd(6'h21, r); check("R3 ready cleared", r, 32'h0);
    wr(6'd3, 32'h5555_AAAA);
    check("R4 partial held", W'(coreStart), 32'h0);
    wr(6'd15, 32'hA000_000F);
    check("R2 no start yet", W'(coreStart), 32'h0);
    tick();
    check("R2 start", W'(coreStart), 32'h1);
    check("R5 overwritten word", coreBlock[3*W +: W], 32'h5555_AAAA);
    check("R2 word 7", coreBlock[7*W +: W], 32'hA000_0007);
    check("R2 word 15", coreBlock[15*W +: W], 32'hA000_000F);
    check("R2 mask", W'(coreWordMask), 32'hFFFF);
    check("R2 last", W'(coreLast), 32'h0);
    check("R7 no dma when off", W'(dmaReq), 32'h0);
    rd(6'h21, r); check("R3 ready set", r, 32'h1);
    rd(6'h23, r); check("R11 count 64", r, 32'd64);
    tick();
    check("R2 start one cycle", W'(coreStart), 32'h0);

    // R6 second block waits for block-done
    fillBlock(32'hB000_0000);
    tick(); tick();
    check("R6 held while busy", W'(coreStart), 32'h0);
    rd(6'h21, r); check("R6 ready low while held", r, 32'h0);
    pulseDone(1'b0);
    check("R6 not before done edge", W'(coreStart), 32'h0);
    tick();
    check("R6 start after done", W'(coreStart), 32'h1);
    check("R6 block word 9", coreBlock[9*W +: W], 32'hB000_0009);
    pulseDone(1'b0);

    // R7 DMA requests
    wr(6'h20, 32'h1);
    check("R7 dma on enable", W'(dmaReq), 32'h1);
    tick();
    check("R7 dma pulse", W'(dmaReq), 32'h0);
    fillBlock(32'hC000_0000);
    tick();
    check("R7 dma on handoff", W'(dmaReq), 32'h1);
    check("R7 start with dma", W'(coreStart), 32'h1);
    pulseDone(1'b0);
    wr(6'h20, 32'h0);

    // R4 close with a partial block
    wr(6'd0, 32'h1111_0000);
    wr(6'd1, 32'h1111_0001);
    wr(6'd2, 32'h1111_0002);
    tick(); tick();
    check("R4 partial held", W'(coreStart), 32'h0);
    wr(6'h20, 32'h4);
    tick();
    check("R4 close start", W'(coreStart), 32'h1);
    check("R4 close mask", W'(coreWordMask), 32'h0007);
    check("R4 close last", W'(coreLast), 32'h1);
    rd(6'h20, r); check("R4 close self clears", r, 32'h0);
    rd(6'h23, r); check("R11 partial count", r, 32'd64 * 3 + 32'd12);
    pulseDone(1'b0);

    // R8 / R9 completion flag and interrupt
    wr(6'h22, 32'h0);
    wr(6'h20, 32'h2);
    pulseDone(1'b1);
    rd(6'h21, r); check("R8 out-ready despite mask", r, 32'h3);
    check("R9 irq masked", W'(irqN), 32'h1);
    wr(6'h22, 32'h2);
    check("R9 irq low", W'(irqN), 32'h0);
    wr(6'h20, 32'h0);
    check("R9 irq off when disabled", W'(irqN), 32'h1);
    wr(6'h20, 32'h2);
    check("R9 irq back", W'(irqN), 32'h0);
    wr(6'h21, 32'h2);
    rd(6'h21, r); check("R8 w1c", r, 32'h1);
    check("R9 irq released", W'(irqN), 32'h1);

    // R10 digest visibility per algorithm
    for (int v = 0; v < NVEC; v++) begin
      logic [2:0] algo;
      logic [3:0] idx;
      logic ok;
      logic [W-1:0] exp;
      algo = DIG_VEC[v][8:6];
      idx = DIG_VEC[v][5:2];
      ok = DIG_VEC[v][1];
      exp = ok ? (32'hD000_0000 + W'(idx)) : 32'h0;
      wr(6'h20, W'({algo, 4'b0000}));
      rd(6'h10 + 6'(idx), r);
      check("R10 digest word", r, exp);
    end
    wr(6'h20, 32'h0);

    // R11 restore count then add a block
    wr(6'h23, 32'd1000);
    fillBlock(32'hE000_0000);
    tick();
    rd(6'h23, r); check("R11 restored count", r, 32'd1064);
    pulseDone(1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule